// File: doc/BRIEF.md
# Watermark-Driven Byte Queue Pair with Sticky Interrupt Flags

This block sits between a processor register port and a serial shift engine. It holds two byte queues: an outbound queue that software fills and the shift engine drains, and an inbound queue that the shift engine fills and software drains. Both queues have the same depth, set by a parameter (128 by default, 64 as the smaller build). Software sees each queue's fill level in a status word. It can empty either queue at once through a bit that clears itself.

Two programmable watermarks turn queue levels into requests. The inbound request fires once the inbound level reaches its watermark. The outbound request fires once the outbound level falls to its watermark. Both watermarks reset to three quarters of the depth. A byte pushed into a full inbound queue is lost, and an overrun flag records the loss. A pulse from the shift engine marks the end of a transfer. All four flags are sticky and are cleared by writing ones. Each flag is masked by its own enable bit, and the single interrupt line is the OR of the enabled flags.

The shift engine is not part of this block. It sees only a pop strobe with a head byte on the outbound side, a push strobe with a byte on the inbound side, and a done pulse.

Top module: `fifo_pair_irq`

## Requirements
- R1: Each write of register address 4 appends wdata[7:0] to the outbound queue. A write while that queue holds DEPTH bytes is dropped. tx_avail is high whenever the queue holds any byte, and tx_byte shows the oldest byte (0 when the queue is empty). A tx_pop while the queue is not empty removes that byte.
- R2: rx_push appends rx_byte to the inbound queue unless the queue already holds DEPTH bytes. A pop in the same cycle does not make room for it. While rd_en is high at address 5, rdata shows the oldest inbound byte and the byte is removed at the clock edge. An empty inbound queue reads as 0.
- R3: Address 1 reads the inbound fill count from bit 0 upward and the outbound fill count from bit 16 upward. Each count is $clog2(DEPTH+1) bits wide.
- R4: Address 0 holds the inbound watermark in bits 7:0 and the outbound watermark in bits 23:16. Writing 1 to bit 15 empties the inbound queue, and writing 1 to bit 31 empties the outbound queue. Bits 15 and 31 always read 0. Both watermarks reset to DEPTH*3/4.
- R5: Flag bit 0 (inbound ready) sets on the edge after a cycle in which the inbound count is at or above the inbound watermark. Flag bit 4 (outbound request) sets on the edge after a cycle in which the outbound count is at or below the outbound watermark.
- R6: Flag bit 8 (overrun) sets on the edge after an rx_push that finds the inbound queue full.
- R7: Flag bit 12 (done) sets on the edge after an xfer_done pulse.
- R8: Flags are read at address 3 and stay set until cleared. Writing address 3 clears every flag whose bit position holds a 1, so writing all ones clears them all. The clear wins over a set in the same cycle, and a flag whose condition still holds sets again one cycle later.
- R9: Address 2 holds the enable bits at positions 0, 4, 8 and 12, and all other bits read 0. irq is high exactly when some flag and its enable bit are both set. Addresses 4, 6 and 7 read 0.
- R10: A flush empties its queue at the next edge and overrides a push or pop to that queue in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the inbound queue at address 5) |
| addr | input | 3 | Register address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for the current address |
| tx_pop | input | 1 | Shift engine takes the outbound head byte |
| tx_byte | output | 8 | Outbound head byte |
| tx_avail | output | 1 | Outbound queue not empty |
| rx_push | input | 1 | Shift engine delivers a byte |
| rx_byte | input | 8 | Inbound byte |
| xfer_done | input | 1 | End-of-transfer pulse |
| irq | output | 1 | Enabled-flag interrupt |

## Verification
The hardest state to reach from the ports is an inbound queue that is full while the overrun flag is being cleared and re-set. Reaching it needs more than DEPTH pushes with no reads in between, followed by clears that race against further pushes. The stimulus drives a long burst of rx_push well past DEPTH, writes all-ones clears while pushes continue, and then moves the watermarks so that the ready and request flags re-set on the cycle after a clear. A random phase mixes flushes with same-cycle pushes and pops. A behavioural queue model is compared against every output on every cycle.

// File: rtl/fifo_pair_irq_pkg.sv
package fifo_pair_irq_pkg;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_LEVEL = 3'd1,
    A_EN    = 3'd2,
    A_FLAG  = 3'd3,
    A_TXD   = 3'd4,
    A_RXD   = 3'd5
  } reg_addr_e;

  localparam int N_FLAGS = 4;

  // Bit position of compact flag i in the enable and flag words.
  function automatic int flag_pos(input int i);
    return 4 * i;
  endfunction

  function automatic logic [31:0] spread_flags(input logic [N_FLAGS-1:0] f);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < N_FLAGS; i++) w[flag_pos(i)] = f[i];
    return w;
  endfunction

  function automatic logic [N_FLAGS-1:0] gather_flags(input logic [31:0] w);
    logic [N_FLAGS-1:0] f;
    for (int i = 0; i < N_FLAGS; i++) f[i] = w[flag_pos(i)];
    return f;
  endfunction

  function automatic int default_level(input int depth);
    return (depth * 3) / 4;
  endfunction

  function automatic logic [31:0] pack_levels(input logic [7:0] rxc, input logic [7:0] txc);
    return {8'h00, txc, 8'h00, rxc};
  endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 128,
  parameter int W     = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end
endmodule

// File: rtl/sticky_flags.sv
module sticky_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (clr[i]) flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/fifo_pair_irq.sv
module fifo_pair_irq
  import fifo_pair_irq_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int LVL_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        tx_pop,
  output logic [7:0]  tx_byte,
  output logic        tx_avail,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        xfer_done,
  output logic        irq
);
  localparam logic [LVL_W-1:0] LVL_RST = LVL_W'(default_level(DEPTH));

  logic [LVL_W-1:0]   rx_lvl, tx_lvl;
  logic [N_FLAGS-1:0] en, flags, ev_set, ev_clr;
  logic [CNT_W-1:0]   rx_cnt, tx_cnt;
  logic [7:0]         rx_dout, tx_dout;
  logic               rx_full, rx_empty, tx_full, tx_empty;

  // named internal events
  logic wr_ctrl, wr_en_reg, wr_flag, wr_txd, rd_rxd;
  logic rx_flush, tx_flush;
  logic ev_rx_ready, ev_tx_req, ev_overrun, ev_done;

  assign wr_ctrl   = wr_en && (addr == A_CTRL);
  assign wr_en_reg = wr_en && (addr == A_EN);
  assign wr_flag   = wr_en && (addr == A_FLAG);
  assign wr_txd    = wr_en && (addr == A_TXD);
  assign rd_rxd    = rd_en && (addr == A_RXD);
  assign rx_flush  = wr_ctrl && wdata[15];
  assign tx_flush  = wr_ctrl && wdata[31];

  byte_fifo #(.DEPTH(DEPTH), .W(8)) u_tx (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(wr_txd), .din(wdata[7:0]),
    .pop(tx_pop), .dout(tx_dout), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rx (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push), .din(rx_byte),
    .pop(rd_rxd), .dout(rx_dout), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_lvl <= LVL_RST;
      tx_lvl <= LVL_RST;
      en     <= '0;
    end else begin
      if (wr_ctrl) begin
        rx_lvl <= wdata[7:0];
        tx_lvl <= wdata[23:16];
      end
      if (wr_en_reg) en <= gather_flags(wdata);
    end
  end

  assign ev_rx_ready = 16'(rx_cnt) >= 16'(rx_lvl);
  assign ev_tx_req   = 16'(tx_cnt) <= 16'(tx_lvl);
  assign ev_overrun  = rx_push && rx_full;
  assign ev_done     = xfer_done;

  assign ev_set = {ev_done, ev_overrun, ev_tx_req, ev_rx_ready};
  assign ev_clr = wr_flag ? gather_flags(wdata) : '0;

  sticky_flags #(.N(N_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(ev_clr), .flags(flags)
  );

  assign irq      = |(flags & en);
  assign tx_avail = ~tx_empty;
  assign tx_byte  = tx_empty ? 8'h00 : tx_dout;

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {8'h00, tx_lvl, 8'h00, rx_lvl};
      A_LEVEL: rdata = pack_levels(8'(rx_cnt), 8'(tx_cnt));
      A_EN:    rdata = spread_flags(en);
      A_FLAG:  rdata = spread_flags(flags);
      A_RXD:   rdata = rx_empty ? 32'h0 : {24'h0, rx_dout};
      default: rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/fifo_pair_irq_chk.sv
module fifo_pair_irq_chk
  import fifo_pair_irq_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [2:0]       addr,
  input logic [31:0]      wdata,
  input logic             rx_push,
  input logic             xfer_done,
  input logic             irq,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [3:0]       flags
);
  logic flag_wr, rx_pop, ctrl_wr;
  assign flag_wr = wr_en && (addr == A_FLAG);
  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign rx_pop  = rd_en && (addr == A_RXD);

  p_tx_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CNT_W'(DEPTH));

  p_rx_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == CNT_W'(DEPTH) && rx_push && !rx_pop && !(ctrl_wr && wdata[15]))
    |=> rx_cnt == CNT_W'(DEPTH));

  p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == CNT_W'(DEPTH) && rx_push && !(flag_wr && wdata[8])) |=> flags[2]);

  p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !(flag_wr && wdata[12])) |=> flags[3]);

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && wdata[0]) |=> !flags[0]);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !(flag_wr && wdata[4])) |=> flags[1]);

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 4'b0) |-> !irq);

  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[31]) |=> tx_cnt == '0);
endmodule

bind fifo_pair_irq fifo_pair_irq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rx_push(rx_push), .xfer_done(xfer_done), .irq(irq),
  .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .flags(flags)
);

// File: tb/tb_fifo_pair_irq.sv
`timescale 1ns/1ps
module tb_fifo_pair_irq;
  localparam int DEPTH = 128;

  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, rd_en = 0, tx_pop = 0, rx_push = 0, xfer_done = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [7:0]  rx_byte = 0;
  logic [31:0] rdata;
  logic [7:0]  tx_byte;
  logic        tx_avail, irq;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  fifo_pair_irq #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_pop(tx_pop), .tx_byte(tx_byte),
    .tx_avail(tx_avail), .rx_push(rx_push), .rx_byte(rx_byte),
    .xfer_done(xfer_done), .irq(irq)
  );

  always #5 clk = ~clk;

  // behavioural reference
  logic [7:0] mq_tx[$], mq_rx[$];
  int  m_rxl, m_txl;
  bit  m_fl[4], m_en[4];

  function automatic logic [31:0] widen(input bit b[4]);
    logic [31:0] v = 0;
    foreach (b[i]) if (b[i]) v = v | (32'h1 << (i * 4));
    return v;
  endfunction

  always @(posedge clk) begin
    int rs, ts;
    bit st[4], cl[4];
    if (!rst_n) begin
      mq_tx.delete(); mq_rx.delete();
      m_rxl = DEPTH * 3 / 4; m_txl = DEPTH * 3 / 4;
      foreach (m_fl[i]) begin m_fl[i] = 0; m_en[i] = 0; end
    end else begin
      rs = mq_rx.size(); ts = mq_tx.size();
      st[0] = rs >= m_rxl; st[1] = ts <= m_txl;
      st[2] = rx_push && rs == DEPTH; st[3] = xfer_done;
      foreach (cl[i]) cl[i] = wr_en && addr == 3 && wdata[i*4];
      foreach (m_fl[i]) m_fl[i] = !cl[i] && (m_fl[i] || st[i]);
      if (wr_en && addr == 2) foreach (m_en[i]) m_en[i] = wdata[i*4];
      if (wr_en && addr == 0) begin
        m_rxl = wdata[7:0]; m_txl = wdata[23:16];
      end
      if (wr_en && addr == 0 && wdata[15]) mq_rx.delete();
      else begin
        if (rd_en && addr == 5 && rs > 0) void'(mq_rx.pop_front());
        if (rx_push && rs < DEPTH) mq_rx.push_back(rx_byte);
      end
      if (wr_en && addr == 0 && wdata[31]) mq_tx.delete();
      else begin
        if (tx_pop && ts > 0) void'(mq_tx.pop_front());
        if (wr_en && addr == 4 && ts < DEPTH) mq_tx.push_back(wdata[7:0]);
      end
    end
  end

  function automatic logic [31:0] exp_rdata();
    case (addr)
      3'd0: return {8'h0, 8'(m_txl), 8'h0, 8'(m_rxl)};
      3'd1: return (32'(mq_tx.size()) << 16) | 32'(mq_rx.size());
      3'd2: return widen(m_en);
      3'd3: return widen(m_fl);
      3'd5: return mq_rx.size() > 0 ? {24'h0, mq_rx[0]} : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rtag();
    case (addr)
      3'd0: return "R4";
      3'd1: return "R3/R10";
      3'd2: return "R9";
      3'd3: return "R5/R6/R7/R8";
      3'd5: return "R2";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit any;
    if (rst_n) begin
      any = 0;
      foreach (m_fl[i]) any = any || (m_fl[i] && m_en[i]);
      check("R9 irq", 32'(irq), 32'(any));
      check("R1 tx_avail", 32'(tx_avail), 32'(mq_tx.size() > 0));
      check("R1 tx_byte", 32'(tx_byte), mq_tx.size() > 0 ? 32'(mq_tx[0]) : 32'h0);
      check(rtag(), rdata, exp_rdata());
    end
  end

  task automatic step(input bit w, input bit r, input logic [2:0] a, input logic [31:0] d,
                      input bit pu = 0, input logic [7:0] b = 0, input bit po = 0, input bit dn = 0);
    @(negedge clk); #1;
    wr_en = w; rd_en = r; addr = a; wdata = d;
    rx_push = pu; rx_byte = b; tx_pop = po; xfer_done = dn;
  endtask

  task automatic look(input logic [2:0] a); step(0, 0, a, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R4 reset levels, R3 empty counts, R9 enables zero
    look(0); look(1); look(2); look(3);
    step(1, 0, 2, 32'h1111);                                    // R9 enable all
    step(1, 0, 3, 32'hFFFF_FFFF); look(3);                      // R8 clear all, R5 re-set
    for (int i = 0; i < 100; i++) step(1, 0, 4, 32'(i + 8'h30)); // R1 fill
    look(1); look(3);
    step(1, 0, 3, 32'h10); look(3); look(3);                     // R8 tx request stays clear above level
    for (int i = 0; i < 10; i++) step(0, 0, 1, 0, 0, 0, 1);      // R1 pops
    look(3);                                                     // R5 tx request at level
    for (int i = 0; i < 135; i++) step(0, 0, 1, 0, 1, 8'(i * 7)); // R2 R6 overflow
    look(3);
    step(1, 0, 3, 32'hFFFF_FFFF, 1, 8'hAA); look(3); look(3);   // R8 clear races push
    for (int i = 0; i < 20; i++) step(0, 1, 5, 0);               // R2 reads
    step(1, 0, 0, 32'h0005_0010); look(0); look(3);              // R4 new levels
    step(0, 0, 3, 0, 0, 0, 0, 1); look(3);                       // R7 done
    step(1, 0, 2, 32'h1000); look(3);                            // R9 mask
    step(1, 0, 0, 32'h8005_8010, 1, 8'h55, 1); look(1); look(0); // R10 flush overrides
    for (int i = 0; i < 140; i++) step(1, 0, 4, 32'(i));         // R1 write past full
    look(1);
    step(1, 0, 0, 32'h8000_0000); look(1);                       // R10
    step(1, 0, 2, 32'hFFFF_FFFF); look(2);                       // R9 reserved bits read 0
    for (int i = 0; i < 6000; i++) begin
      int k = $urandom_range(0, 19);
      logic [2:0] a = 3'($urandom_range(0, 7));
      logic [31:0] d = $urandom;
      if (k == 0) d = d & 32'h7FFF_7FFF | (($urandom_range(0, 1)) ? 32'h8000 : 32'h8000_0000);
      else d = d & 32'h7FFF_7FFF;
      step(k < 8, $urandom_range(0, 1), (k < 3) ? 3'd4 : a, d,
           $urandom_range(0, 2) == 0, 8'($urandom), $urandom_range(0, 2) == 0,
           $urandom_range(0, 30) == 0);
    end
    look(3);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule